// File: doc/BRIEF.md
# NAND Block Erase and Copy-Back Sequencer

This block sits on the host side of an asynchronous 8-bit NAND flash bus. It runs two operations that never move page data across the bus: erasing a whole block, and copy-back, which moves a page inside the device from one location to another. A request gives the operation, a 24-bit source (or block) address and a 24-bit destination address. The block then drives chip enable, command latch, address latch, write and read strobes, and the data byte. It waits on the ready/busy line and reads the status byte. It reports a two-bit result code: 0 pass, 1 fail, 2 plane violation, 3 timeout.

Strobe low and high widths come from configuration inputs counted in clocks, so one netlist can serve slow and fast parts. Only one operation can run at a time. The request port stays closed from acceptance until the result pulse.

Top module: `nand_seq_ctrl`

## Requirements
- R1: An erase writes command 0x60, then block address bytes least significant first ({A16,A15,A14,00000}, then {0,A23..A17}), then command 0x D0. Address bits A9..A13 go out as zero whatever the request carries.
- R2: With cfg_row3 high an erase sends a third address byte of 0x00. With cfg_row3 low it sends exactly two address bytes.
- R3: A copy-back writes 0x00 and three source bytes (A7..A0, A16..A9, {0,A23..A17}), then waits for ready, then writes 0x8A and the three destination bytes in the same layout. It adds 0x10 only when req_confirm is high, and the result code does not depend on req_confirm.
- R4: A copy-back whose source and destination differ in A23 yields done_code 2 one cycle after acceptance. It makes no strobe, and chip enable stays high.
- R5: After the final ready wait the block writes command 0x70 and makes one read-enable cycle. A status bit 0 of 0 gives done_code 0, and a 1 gives done_code 1.
- R6: A command cycle has CLE high and ALE low. An address cycle has ALE high and CLE low. The byte is driven, with nand_dq_oe high, until after write enable rises, and nand_dq_oe is low while read enable is low.
- R7: Each write- or read-enable low pulse lasts exactly max(cfg_strobe_low,1) clocks. Between strobes of one operation the strobe stays high for at least max(cfg_strobe_high,1) clocks.
- R8: If ready has not returned within cfg_busy_limit clocks of the start of a busy wait, the operation ends with done_code 3 and no status read.
- R9: req_ready falls on the cycle after acceptance and stays low until done_valid. done_valid is a one-cycle pulse, and req_ready is high again on the next cycle.
- R10: Chip enable is low for every strobe of an operation and high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this cycle if valid |
| req_op | input | 1 | 0 block erase, 1 copy-back |
| req_src | input | 24 | Erase block address or copy-back source |
| req_dst | input | 24 | Copy-back destination |
| req_confirm | input | 1 | Copy-back also sends the 0x10 confirm |
| cfg_row3 | input | 1 | Erase uses three address bytes |
| cfg_strobe_low | input | 8 | Strobe low width in clocks (0 treated as 1) |
| cfg_strobe_high | input | 8 | Strobe high width in clocks (0 treated as 1) |
| cfg_busy_limit | input | 20 | Busy wait limit in clocks |
| done_valid | output | 1 | Result pulse |
| done_code | output | 2 | 0 pass, 1 fail, 2 plane, 3 timeout |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_out | output | 8 | Byte driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte read from the device |
| nand_rb_n | input | 1 | Ready (high) / busy (low) |

## Verification
The bench uses a behavioural device model that logs every latched byte and pulls busy low after each operation trigger. It targets the masking of A9..A13 on erase: a controller that forwarded those bits would log a nonzero low bits field for an all-ones block address. Zero strobe widths are exercised, where a counter without the max-of-one rule would produce a strobe too long or one that never ends. A copy-back with a fail status and the optional confirm command is run, so that a controller that skipped the confirm or read status too early would log the wrong sequence or code. Two further cases are a plane mismatch, where a careless controller would still toggle strobes, and a stuck-busy device, where a controller without the timeout would hang until the watchdog fires.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int ADDR_W    = 24;
    localparam int ROW_W     = ADDR_W - 9;
    localparam int PLANE_BIT = ADDR_W - 1;

    typedef enum logic {OP_ERASE = 1'b0, OP_COPY = 1'b1} op_e;

    typedef enum logic [2:0] {
        K_CMD  = 3'd0,
        K_ADDR = 3'd1,
        K_READ = 3'd2,
        K_WAIT = 3'd3,
        K_NOP  = 3'd4,
        K_END  = 3'd5
    } step_e;

    typedef enum logic [1:0] {
        RES_PASS    = 2'd0,
        RES_FAIL    = 2'd1,
        RES_PLANE   = 2'd2,
        RES_TIMEOUT = 2'd3
    } res_e;

    localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_PAGE_LOAD   = 8'h00;
    localparam logic [7:0] CMD_COPY_DEST   = 8'h8A;
    localparam logic [7:0] CMD_PROG_GO     = 8'h10;
    localparam logic [7:0] CMD_STATUS      = 8'h70;

    // What the sequencer does at step idx of an operation.
    function automatic step_e step_kind(op_e op, logic [3:0] idx, logic row3, logic confirm);
        step_e k;
        k = K_END;
        if (op == OP_ERASE) begin
            case (idx)
                4'd0:       k = K_CMD;
                4'd1, 4'd2: k = K_ADDR;
                4'd3:       k = row3 ? K_ADDR : K_NOP;
                4'd4:       k = K_CMD;
                4'd5:       k = K_WAIT;
                4'd6:       k = K_CMD;
                4'd7:       k = K_READ;
                default:    k = K_END;
            endcase
        end else begin
            case (idx)
                4'd0:             k = K_CMD;
                4'd1, 4'd2, 4'd3: k = K_ADDR;
                4'd4:             k = K_WAIT;
                4'd5:             k = K_CMD;
                4'd6, 4'd7, 4'd8: k = K_ADDR;
                4'd9:             k = confirm ? K_CMD : K_NOP;
                4'd10:            k = K_WAIT;
                4'd11:            k = K_CMD;
                4'd12:            k = K_READ;
                default:          k = K_END;
            endcase
        end
        return k;
    endfunction

    // Byte driven at step idx. Rows are address bits [23:9], columns [7:0].
    function automatic logic [7:0] step_byte(op_e op, logic [3:0] idx,
                                             logic [7:0] src_col, logic [ROW_W-1:0] src_row,
                                             logic [7:0] dst_col, logic [ROW_W-1:0] dst_row);
        logic [7:0] b;
        b = 8'h00;
        if (op == OP_ERASE) begin
            case (idx)
                4'd0:    b = CMD_ERASE_SETUP;
                4'd1:    b = {src_row[7:5], 5'b00000};
                4'd2:    b = {1'b0, src_row[ROW_W-1:8]};
                4'd4:    b = CMD_ERASE_GO;
                4'd6:    b = CMD_STATUS;
                default: b = 8'h00;
            endcase
        end else begin
            case (idx)
                4'd0:    b = CMD_PAGE_LOAD;
                4'd1:    b = src_col;
                4'd2:    b = src_row[7:0];
                4'd3:    b = {1'b0, src_row[ROW_W-1:8]};
                4'd5:    b = CMD_COPY_DEST;
                4'd6:    b = dst_col;
                4'd7:    b = dst_row[7:0];
                4'd8:    b = {1'b0, dst_row[ROW_W-1:8]};
                4'd9:    b = CMD_PROG_GO;
                4'd11:   b = CMD_STATUS;
                default: b = 8'h00;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/nand_bus_phy.sv
module nand_bus_phy
    import nand_seq_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  step_e         kind,
    input  logic [7:0]    wbyte,
    input  logic [TW-1:0] low_w,
    input  logic [TW-1:0] high_w,
    input  logic [7:0]    dq_in,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    output logic          done,
    output logic [7:0]    rdata
);

    typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH} ph_e;

    typedef struct packed {
        ph_e           ph;
        step_e         kind;
        logic [7:0]    byte_v;
        logic [TW-1:0] cnt;
        logic [7:0]    rdata;
    } phy_t;

    localparam logic [TW-1:0] ONE = TW'(1);

    phy_t q, d;
    logic [TW-1:0] low_eff, high_eff;

    assign low_eff  = (low_w  == '0) ? ONE : low_w;
    assign high_eff = (high_w == '0) ? ONE : high_w;

    always_comb begin
        d    = q;
        done = 1'b0;
        case (q.ph)
            P_IDLE: begin
                if (start) begin
                    d.ph     = P_LOW;
                    d.kind   = kind;
                    d.byte_v = wbyte;
                    d.cnt    = low_eff - ONE;
                end
            end
            P_LOW: begin
                if (q.cnt == '0) begin
                    d.ph  = P_HIGH;
                    d.cnt = high_eff - ONE;
                    if (q.kind == K_READ) d.rdata = dq_in;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            P_HIGH: begin
                if (q.cnt == '0) begin
                    d.ph = P_IDLE;
                    done = 1'b1;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            default: d.ph = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: P_IDLE, kind: K_NOP, byte_v: 8'h00, cnt: '0, rdata: 8'h00};
        end else begin
            q <= d;
        end
    end

    assign cle    = (q.ph != P_IDLE) && (q.kind == K_CMD);
    assign ale    = (q.ph != P_IDLE) && (q.kind == K_ADDR);
    assign we_n   = !((q.ph == P_LOW) && (q.kind != K_READ));
    assign re_n   = !((q.ph == P_LOW) && (q.kind == K_READ));
    assign dq_oe  = (q.ph != P_IDLE) && (q.kind != K_READ);
    assign dq_out = q.byte_v;
    assign rdata  = q.rdata;

    assert_cle_ale_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);

    assert_done_strobes_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (we_n && re_n));

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int CW    = 20,
    parameter int GUARD = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rb_n,
    input  logic [CW-1:0] limit,
    output logic          ok,
    output logic          expired
);

    localparam logic [CW-1:0] GUARD_C = CW'(GUARD);

    typedef struct packed {
        logic [1:0]    sync;
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;
    logic rb_s;

    assign rb_s    = q.sync[1];
    assign ok      = q.run && rb_s && (q.cnt >= GUARD_C);
    assign expired = q.run && !ok && (q.cnt >= limit);

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rb_n};
        if (start) begin
            d.run = 1'b1;
            d.cnt = '0;
        end else if (q.run) begin
            if (ok || expired) d.run = 1'b0;
            else               d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 2'b11, run: 1'b0, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assert_wait_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ok || expired) |=> !q.run || $past(start));

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
    import nand_seq_pkg::*;
#(
    parameter int TW    = 8,
    parameter int CW    = 20,
    parameter int GUARD = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_op,
    input  logic [23:0]   req_src,
    input  logic [23:0]   req_dst,
    input  logic          req_confirm,
    input  logic          cfg_row3,
    input  logic [TW-1:0] cfg_strobe_low,
    input  logic [TW-1:0] cfg_strobe_high,
    input  logic [CW-1:0] cfg_busy_limit,
    output logic          done_valid,
    output logic [1:0]    done_code,
    output logic          nand_ce_n,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic [7:0]    nand_dq_out,
    output logic          nand_dq_oe,
    input  logic [7:0]    nand_dq_in,
    input  logic          nand_rb_n
);

    typedef enum logic [2:0] {S_IDLE, S_STEP, S_PHY, S_BUSY, S_REPORT} st_e;

    typedef struct packed {
        st_e               st;
        logic [3:0]        idx;
        op_e               op;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic              row3;
        logic              confirm;
        logic              ce;
        res_e              res;
    } ctl_t;

    ctl_t q, d;

    step_e      cur_kind;
    logic [7:0] cur_byte;
    logic       phy_start, phy_done;
    logic [7:0] phy_rdata;
    logic       tmr_start, tmr_ok, tmr_expired;
    logic       plane_bad;
    logic       unused_bits;

    assign cur_kind = step_kind(q.op, q.idx, q.row3, q.confirm);
    assign cur_byte = step_byte(q.op, q.idx,
                                q.src[7:0], q.src[ADDR_W-1:9],
                                q.dst[7:0], q.dst[ADDR_W-1:9]);

    assign plane_bad = req_op && (req_src[PLANE_BIT] != req_dst[PLANE_BIT]);

    assign phy_start = (q.st == S_STEP) &&
                       ((cur_kind == K_CMD) || (cur_kind == K_ADDR) || (cur_kind == K_READ));
    assign tmr_start = (q.st == S_STEP) && (cur_kind == K_WAIT);

    // Half-page selector and upper status bits have no role in these operations.
    assign unused_bits = ^{q.src[8], q.dst[8], phy_rdata[7:1]};

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.op      = op_e'(req_op);
                    d.src     = req_src;
                    d.dst     = req_dst;
                    d.row3    = cfg_row3;
                    d.confirm = req_confirm;
                    d.idx     = 4'd0;
                    if (plane_bad) begin
                        d.st  = S_REPORT;
                        d.res = RES_PLANE;
                    end else begin
                        d.st  = S_STEP;
                        d.ce  = 1'b1;
                        d.res = RES_PASS;
                    end
                end
            end
            S_STEP: begin
                case (cur_kind)
                    K_NOP:   d.idx = q.idx + 4'd1;
                    K_END:   d.st  = S_REPORT;
                    K_WAIT:  d.st  = S_BUSY;
                    default: d.st  = S_PHY;
                endcase
            end
            S_PHY: begin
                if (phy_done) begin
                    if (cur_kind == K_READ)
                        d.res = phy_rdata[0] ? RES_FAIL : RES_PASS;
                    d.idx = q.idx + 4'd1;
                    d.st  = S_STEP;
                end
            end
            S_BUSY: begin
                if (tmr_ok) begin
                    d.idx = q.idx + 4'd1;
                    d.st  = S_STEP;
                end else if (tmr_expired) begin
                    d.res = RES_TIMEOUT;
                    d.st  = S_REPORT;
                end
            end
            S_REPORT: begin
                d.st = S_IDLE;
                d.ce = 1'b0;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, idx: 4'd0, op: OP_ERASE, src: '0, dst: '0,
                   row3: 1'b0, confirm: 1'b0, ce: 1'b0, res: RES_PASS};
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == S_IDLE);
    assign done_valid = (q.st == S_REPORT);
    assign done_code  = q.res;
    assign nand_ce_n  = !q.ce;

    nand_bus_phy #(.TW(TW)) u_phy (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (phy_start),
        .kind   (cur_kind),
        .wbyte  (cur_byte),
        .low_w  (cfg_strobe_low),
        .high_w (cfg_strobe_high),
        .dq_in  (nand_dq_in),
        .cle    (nand_cle),
        .ale    (nand_ale),
        .we_n   (nand_we_n),
        .re_n   (nand_re_n),
        .dq_out (nand_dq_out),
        .dq_oe  (nand_dq_oe),
        .done   (phy_done),
        .rdata  (phy_rdata)
    );

    nand_busy_timer #(.CW(CW), .GUARD(GUARD)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .rb_n    (nand_rb_n),
        .limit   (cfg_busy_limit),
        .ok      (tmr_ok),
        .expired (tmr_expired)
    );

    assert_plane_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && plane_bad) |=> (done_valid && (done_code == 2'd2) && nand_ce_n));

    assert_closed_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    assert_ce_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    assert_timeout_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_BUSY && !tmr_ok && tmr_expired) |=> (done_valid && done_code == 2'd3));

endmodule

// File: tb/nand_seq_ctrl_tb.sv
module nand_seq_ctrl_tb;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_op, req_confirm;
    logic [23:0] req_src, req_dst;
    logic        cfg_row3;
    logic [7:0]  cfg_strobe_low, cfg_strobe_high;
    logic [19:0] cfg_busy_limit;
    logic        done_valid;
    logic [1:0]  done_code;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        rb_n_m = 1'b1;

    int total = 0;
    int bad   = 0;

    // device model configuration, written only by the stimulus process
    int   busy_len_m = 10;
    logic fail_m     = 1'b0;
    int   exp_lo     = 1;
    int   exp_hi     = 1;

    // device model state, written only by the model process
    int         dly_m = 0, busy_m = 0, acnt_m = 0;
    logic [7:0] last_cmd_m = 8'h00;
    logic       prev_we = 1'b1, prev_re = 1'b1;
    int         low_run = 0, high_run = 0;
    bit         seen = 0;
    int         width_err = 0, gap_err = 0, ce_err = 0;
    logic [9:0] log_q[$];
    logic [9:0] exp_q[$];

    always #(CLK_NS/2) clk = ~clk;

    assign nand_dq_in = !nand_re_n ? {7'b1100000, fail_m} : 8'h00;

    nand_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_src(req_src), .req_dst(req_dst), .req_confirm(req_confirm),
        .cfg_row3(cfg_row3), .cfg_strobe_low(cfg_strobe_low),
        .cfg_strobe_high(cfg_strobe_high), .cfg_busy_limit(cfg_busy_limit),
        .done_valid(done_valid), .done_code(done_code),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb_n(rb_n_m)
    );

    // Behavioural device: logs latched bytes, measures strobes, drives busy.
    always @(negedge clk) begin
        if (!rst_n) begin
            rb_n_m = 1'b1; dly_m = 0; busy_m = 0; acnt_m = 0; last_cmd_m = 8'h00;
            low_run = 0; high_run = 0; seen = 0; prev_we = 1'b1; prev_re = 1'b1;
        end else begin
            if (dly_m > 0) begin
                dly_m--;
                if (dly_m == 0) begin rb_n_m = 1'b0; busy_m = busy_len_m; end
            end else if (busy_m > 0) begin
                busy_m--;
                if (busy_m == 0) rb_n_m = 1'b1;
            end
            if (!nand_we_n || !nand_re_n) begin
                if (prev_we && prev_re) begin
                    if (seen && high_run < exp_hi) gap_err++;
                    high_run = 0;
                end
                low_run++;
            end else begin
                if (!prev_we || !prev_re) begin
                    if (low_run != exp_lo) width_err++;
                    low_run = 0;
                    seen = 1;
                    if (nand_ce_n) ce_err++;
                    if (!prev_we) begin
                        log_q.push_back({nand_cle, nand_ale, nand_dq_out});
                        if (nand_cle) begin
                            last_cmd_m = nand_dq_out;
                            acnt_m = 0;
                            if (nand_dq_out == 8'hD0 ||
                                (nand_dq_out == 8'h10 && busy_m == 0 && dly_m == 0))
                                dly_m = 2;
                        end
                        if (nand_ale) begin
                            acnt_m++;
                            if (acnt_m == 3 && (last_cmd_m == 8'h00 || last_cmd_m == 8'h8A))
                                dly_m = 2;
                        end
                    end else begin
                        log_q.push_back(10'h3FF);
                    end
                end
                high_run++;
            end
            if (nand_ce_n) seen = 0;
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [9:0] c_(input logic [7:0] b); return {2'b10, b}; endfunction
    function automatic logic [9:0] a_(input logic [7:0] b); return {2'b01, b}; endfunction

    task automatic build_exp(input bit op, input logic [23:0] s, input logic [23:0] dd,
                             input bit row3, input bit conf);
        exp_q.delete();
        if (!op) begin
            exp_q.push_back(c_(8'h60));
            exp_q.push_back(a_({s[16:14], 5'b00000}));
            exp_q.push_back(a_({1'b0, s[23:17]}));
            if (row3) exp_q.push_back(a_(8'h00));
            exp_q.push_back(c_(8'hD0));
        end else begin
            exp_q.push_back(c_(8'h00));
            exp_q.push_back(a_(s[7:0]));
            exp_q.push_back(a_(s[16:9]));
            exp_q.push_back(a_({1'b0, s[23:17]}));
            exp_q.push_back(c_(8'h8A));
            exp_q.push_back(a_(dd[7:0]));
            exp_q.push_back(a_(dd[16:9]));
            exp_q.push_back(a_({1'b0, dd[23:17]}));
            if (conf) exp_q.push_back(c_(8'h10));
        end
        exp_q.push_back(c_(8'h70));
        exp_q.push_back(10'h3FF);
    endtask

    task automatic run_op(input bit op, input logic [23:0] s, input logic [23:0] dd,
                          input bit row3, input bit conf, input int lo, input int hi,
                          input bit fail, input int blen, input int limit, input bit want_to);
        int start_n, werr0, gerr0, cerr0, n, first_bad, naddr;
        bit got, plane;
        logic [1:0] expc;
        string rq;
        @(negedge clk);
        cfg_row3 = row3; cfg_strobe_low = lo[7:0]; cfg_strobe_high = hi[7:0];
        cfg_busy_limit = limit[19:0];
        busy_len_m = blen; fail_m = fail;
        exp_lo = (lo == 0) ? 1 : lo; exp_hi = (hi == 0) ? 1 : hi;
        start_n = log_q.size(); werr0 = width_err; gerr0 = gap_err; cerr0 = ce_err;
        req_valid = 1'b1; req_op = op; req_src = s; req_dst = dd; req_confirm = conf;
        @(posedge clk);
        while (!req_ready) @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R9", "ready low after accept", req_ready, 0);
        plane = op && (s[23] != dd[23]);
        expc = plane ? 2'd2 : (want_to ? 2'd3 : (fail ? 2'd1 : 2'd0));
        got = 0;
        for (int c = 0; c < 20000 && !got; c++) begin
            if (done_valid) got = 1;
            else begin
                if (req_ready) check(0, "R9", "ready reopened before done", 1, 0);
                @(negedge clk);
            end
        end
        check(got, "R9", "done pulse seen", got, 1);
        rq = plane ? "R4" : (want_to ? "R8" : (op ? "R3/R5" : "R5"));
        check(done_code == expc, rq, "done code", done_code, expc);
        n = log_q.size() - start_n;
        if (plane) begin
            check(n == 0, "R4", "no strobes on plane reject", n, 0);
            check(nand_ce_n, "R4", "ce stays high on reject", nand_ce_n, 1);
        end else if (!want_to) begin
            build_exp(op, s, dd, row3, conf);
            first_bad = -1;
            for (int i = 0; i < exp_q.size() && i < n; i++)
                if (first_bad < 0 && log_q[start_n + i] != exp_q[i]) first_bad = i;
            if (n != exp_q.size() && first_bad < 0) first_bad = n;
            check(first_bad < 0, op ? "R3" : "R1", "bus sequence",
                  (first_bad >= 0 && first_bad < n) ? 32'(log_q[start_n + first_bad]) : 32'(n),
                  (first_bad >= 0 && first_bad < exp_q.size()) ? 32'(exp_q[first_bad]) : 32'(exp_q.size()));
            if (!op) begin
                naddr = 0;
                for (int i = 0; i < n; i++) if (log_q[start_n + i][9:8] == 2'b01) naddr++;
                check(naddr == (row3 ? 3 : 2), "R2", "erase address byte count", naddr, row3 ? 3 : 2);
            end
        end
        check(width_err == werr0, "R7", "strobe low width", width_err - werr0, 0);
        check(gap_err == gerr0, "R7", "strobe high gap", gap_err - gerr0, 0);
        check(ce_err == cerr0, "R10", "ce low on every strobe", ce_err - cerr0, 0);
        @(negedge clk);
        check(!done_valid && req_ready, "R9", "done one cycle then ready",
              {done_valid, req_ready}, 2'b01);
        check(nand_ce_n, "R10", "ce high when idle", nand_ce_n, 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin
        logic [23:0] s, dd;
        rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0; req_src = '0; req_dst = '0;
        req_confirm = 1'b0; cfg_row3 = 1'b0; cfg_strobe_low = 8'd1;
        cfg_strobe_high = 8'd1; cfg_busy_limit = 20'd2000;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !done_valid, "R9", "reset: ready, no done", {req_ready, done_valid}, 2'b10);
        check(nand_ce_n && nand_we_n && nand_re_n, "R10", "reset: strobes idle",
              {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        check(!nand_cle && !nand_ale && !nand_dq_oe, "R6", "reset: latches low",
              {nand_cle, nand_ale, nand_dq_oe}, 0);

        // R1: low block-address bits must be zeroed
        run_op(0, 24'hFFFFFF, 24'h0, 0, 0, 2, 1, 0, 12, 2000, 0);
        // R2: three-byte erase, failing status (R5)
        run_op(0, 24'h5A3E00, 24'h0, 1, 0, 1, 2, 1, 20, 2000, 0);
        // R7: zero widths behave as one clock
        run_op(0, 24'h123456, 24'h0, 0, 0, 0, 0, 0, 5, 2000, 0);
        // R3: copy-back without and with the optional confirm
        run_op(1, 24'h012345, 24'h0ABCDE, 0, 0, 1, 1, 0, 15, 2000, 0);
        run_op(1, 24'h812345, 24'hFFFFFF, 0, 1, 3, 2, 1, 30, 2000, 0);
        run_op(1, 24'h812345, 24'hFFFFFF, 0, 1, 3, 2, 0, 30, 2000, 0);
        // R4: plane mismatch rejected
        run_op(1, 24'h800000, 24'h000000, 0, 0, 1, 1, 0, 10, 2000, 0);
        // R8: busy never clears within the limit
        run_op(0, 24'h400000, 24'h0, 0, 0, 1, 1, 0, 5000, 100, 1);
        do_reset();
        run_op(1, 24'h000100, 24'h7FFEFF, 0, 1, 2, 3, 0, 8, 2000, 0);

        for (int it = 0; it < 40; it++) begin
            s  = 24'($urandom);
            dd = 24'($urandom);
            if ($urandom % 8 != 0) dd[23] = s[23];
            run_op(1'($urandom % 2), s, dd, 1'($urandom % 2), 1'($urandom % 2),
                   int'($urandom % 4), int'($urandom % 4), 1'($urandom % 2),
                   1 + int'($urandom % 40), 2000, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule